// File: doc/BRIEF.md
# Strobed Serial Byte Receiver

This block takes 8-bit control bytes from a three-wire link made of an active-low frame enable, a serial clock and a data line. A much faster system clock samples all three wires. While the frame enable is low, every rising edge of the serial clock moves one data bit into a shift register, most significant bit first. When the frame enable returns high, the block judges the frame it has just closed.

A frame that held exactly eight serial clock edges is accepted. The block presents the byte on `byte_out` and raises `byte_valid` for one system clock cycle. Any other edge count, from zero up to an arbitrarily long burst, rejects the frame: `frame_error` pulses for one cycle and `byte_out` keeps its previous value. A glitch on the serial clock wire adds an edge, so a corrupted byte is turned away and never handed on as good data.

Top module: `serial_strobe_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `byte_valid` and `frame_error` are low and `byte_out` is 0x00.
- R2: Bits are taken most significant first: the first data bit of a frame appears in bit 7 of `byte_out`, the last one in bit 0.
- R3: A frame that held exactly eight rising serial clock edges while the frame enable was low produces, after the enable rises, exactly one `byte_valid` pulse one cycle long, with `byte_out` equal to the bits shifted in and no `frame_error`. The pulse appears within 6 system cycles of the enable's rising edge at the pin.
- R4: A frame with fewer than eight edges, zero included, produces exactly one `frame_error` pulse one cycle long, no `byte_valid`, and leaves `byte_out` unchanged.
- R5: A frame with more than eight edges is rejected as in R4. The edge count saturates, so bursts of 16 or 24 edges are rejected as well and never wrap round to eight.
- R6: Serial clock edges while the frame enable is high shift nothing, are not counted and produce no pulse.
- R7: `byte_valid` and `frame_error` are never high in the same cycle, and neither stays high for two cycles in a row.
- R8: The edge count restarts at every falling edge of the frame enable, so a good frame after a rejected one is accepted.
- R9: `byte_out` changes only in a cycle where `byte_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_en_n | input | 1 | Frame enable, low while a byte is being sent (asynchronous) |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| byte_out | output | 8 | Last accepted byte |
| byte_valid | output | 1 | One-cycle pulse, frame accepted |
| frame_error | output | 1 | One-cycle pulse, frame rejected |

## Verification
The assertions check on every cycle that the two pulses exclude each other and last one cycle, and that each pulse comes from a frame-enable rise. They also check that an accept follows a count of exactly eight, that the count stays at or below its saturation value, that it holds still while the enable is high, and that it restarts on the enable's fall. Only the bench scenarios can show that the delivered byte carries the bits in the order sent and that a rejected frame leaves the output alone. The same holds for long bursts being refused rather than wrapping, and for stray clocks outside a frame having no lasting effect: each of these needs a known serial sequence to compare against.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    SBR_HOLD   = 2'd0,
    SBR_ACCEPT = 2'd1,
    SBR_REJECT = 2'd2
  } sbr_verdict_e;

  // Verdict on a closed frame: only an exact edge count is accepted.
  function automatic sbr_verdict_e sbr_judge(input int unsigned edges,
                                             input int unsigned target);
    return (edges == target) ? SBR_ACCEPT : SBR_REJECT;
  endfunction

  // Saturating increment: stops at limit so long bursts never wrap.
  function automatic int unsigned sbr_sat_inc(input int unsigned cur,
                                              input int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sbr_edge.sv
module sbr_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);

  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  assign chg = lvl ^ prev;

endmodule

// File: rtl/sbr_frame.sv
module sbr_frame
  import sbr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_low,
  input  logic              en_fall,
  input  logic              en_rise,
  input  logic              sclk_rise,
  input  logic              dat,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_valid,
  output logic              frame_error,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam int unsigned CNT_SAT = BYTE_W + 1;

  logic [BYTE_W-1:0] shreg;
  logic              take_bit;
  sbr_verdict_e      verdict;
  logic [CNT_W-1:0]  cnt_next;

  assign take_bit = sclk_rise & en_low;
  assign verdict  = en_rise ? sbr_judge(int'(bit_cnt), BYTE_W) : SBR_HOLD;
  assign cnt_next = CNT_W'(sbr_sat_inc(int'(bit_cnt), CNT_SAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt     <= '0;
      shreg       <= '0;
      byte_out    <= '0;
      byte_valid  <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      byte_valid  <= 1'b0;
      frame_error <= 1'b0;
      if (take_bit) begin
        shreg   <= {shreg[BYTE_W-2:0], dat};
        bit_cnt <= en_fall ? CNT_W'(1) : cnt_next;
      end else if (en_fall) begin
        bit_cnt <= '0;
      end
      case (verdict)
        SBR_ACCEPT: begin
          byte_valid <= 1'b1;
          byte_out   <= shreg;
        end
        SBR_REJECT: frame_error <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/serial_strobe_rx.sv
module serial_strobe_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_en_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_valid,
  output logic              frame_error
);

  localparam int CNT_W = $clog2(BYTE_W + 2);

  // Synchronised wires: [2] frame enable, [1] serial clock, [0] data.
  logic [2:0] pins;
  logic [2:0] pins_s;
  logic [1:0] chg;

  logic             en_high;
  logic             en_low;
  logic             en_rise;
  logic             en_fall;
  logic             sclk_rise;
  logic [CNT_W-1:0] bit_cnt;

  assign pins = {ser_en_n, ser_clk, ser_dat};

  sbr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins),
    .q   (pins_s)
  );

  sbr_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (pins_s[2:1]),
    .chg (chg)
  );

  assign en_high   = pins_s[2];
  assign en_low    = ~pins_s[2];
  assign en_rise   = chg[1] & pins_s[2];
  assign en_fall   = chg[1] & ~pins_s[2];
  assign sclk_rise = chg[0] & pins_s[1];

  sbr_frame #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .en_low      (en_low),
    .en_fall     (en_fall),
    .en_rise     (en_rise),
    .sclk_rise   (sclk_rise),
    .dat         (pins_s[0]),
    .byte_out    (byte_out),
    .byte_valid  (byte_valid),
    .frame_error (frame_error),
    .bit_cnt     (bit_cnt)
  );

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_valid,
  input logic              frame_error,
  input logic [BYTE_W-1:0] byte_out,
  input logic              en_rise,
  input logic              en_fall,
  input logic              en_high,
  input logic [CNT_W-1:0]  bit_cnt
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid && frame_error)); // R7
  AST_VALID_SHORT: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid); // R7
  AST_ERROR_SHORT: assert property (@(posedge clk) disable iff (rst)
    frame_error |=> !frame_error); // R7
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (byte_valid || frame_error) |-> $past(en_rise)); // R3
  AST_ACCEPT_EIGHT: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> ($past(bit_cnt) == CNT_W'(BYTE_W))); // R3
  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(BYTE_W + 1)); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    en_high |=> $stable(bit_cnt)); // R6
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    en_fall |=> (bit_cnt <= CNT_W'(1))); // R8
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |-> $stable(byte_out)); // R9

endmodule

bind serial_strobe_rx sbr_checker #(.BYTE_W(BYTE_W)) u_sbr_checker (
  .clk         (clk),
  .rst         (rst),
  .byte_valid  (byte_valid),
  .frame_error (frame_error),
  .byte_out    (byte_out),
  .en_rise     (en_rise),
  .en_fall     (en_fall),
  .en_high     (en_high),
  .bit_cnt     (bit_cnt)
);

// File: tb/serial_strobe_rx_bench.sv
`timescale 1ns/1ps
module serial_strobe_rx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_en_n = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic [7:0] byte_out;
  logic       byte_valid;
  logic       frame_error;

  int checks = 0;
  int errors = 0;
  int n_valid = 0;
  int n_error = 0;
  bit done = 1'b0;

  localparam int HALF = 8; // serial half period in system cycles

  always #2 clk = ~clk; // 250 MHz

  serial_strobe_rx u_serial_strobe_rx (
    .clk         (clk),
    .rst         (rst),
    .ser_en_n    (ser_en_n),
    .ser_clk     (ser_clk),
    .ser_dat     (ser_dat),
    .byte_out    (byte_out),
    .byte_valid  (byte_valid),
    .frame_error (frame_error)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid)  n_valid++;
      if (frame_error) n_error++;
    end
  end

  function automatic bit accepted(input int edges);
    return edges == 8;
  endfunction

  // Byte expected from an n-bit MSB-first burst taken from pat[n-1:0].
  function automatic logic [7:0] last_eight(input logic [31:0] pat);
    return pat[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stray_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b1; idle(HALF);
      ser_clk = 1'b0; idle(HALF);
    end
  endtask

  // Sends n edges of pat (pat[n-1] first) and checks the outcome.
  task automatic frame(input int n, input logic [31:0] pat, input string req);
    int v0, e0;
    logic [7:0] prev;
    v0 = n_valid; e0 = n_error; prev = byte_out;
    ser_en_n = 1'b0; idle(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = pat[i];
      idle(HALF);
      ser_clk = 1'b1; idle(HALF);
      ser_clk = 1'b0;
    end
    idle(HALF);
    chk(n_valid == v0 && n_error == e0, req, "pulse before enable rise",
        n_valid - v0 + n_error - e0, 0);
    ser_en_n = 1'b1;
    idle(6);
    if (accepted(n)) begin
      chk(n_valid - v0 == 1, req, "valid pulses", n_valid - v0, 1);
      chk(n_error == e0, req, "error pulses", n_error - e0, 0);
      chk(byte_out == last_eight(pat), req, "byte", byte_out, last_eight(pat));
    end else begin
      chk(n_error - e0 == 1, req, "error pulses", n_error - e0, 1);
      chk(n_valid == v0, req, "valid pulses", n_valid - v0, 0);
      chk(byte_out == prev, req, "byte kept", byte_out, prev);
    end
    idle(2 * HALF);
  endtask

  initial begin
    void'($urandom(32'd7311));
    idle(4);
    chk(byte_valid == 1'b0 && frame_error == 1'b0 && byte_out == 8'h00,
        "R1", "outputs in reset", {byte_valid, frame_error, byte_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(byte_valid == 1'b0 && frame_error == 1'b0 && byte_out == 8'h00,
        "R1", "outputs after reset", {byte_valid, frame_error, byte_out}, 0);
    idle(10);

    frame(8, 32'h80, "R2");        // only first bit set -> bit 7
    frame(8, 32'h01, "R2");        // only last bit set -> bit 0
    frame(8, 32'hA5, "R3");
    frame(0, 32'h0, "R4");
    frame(7, 32'h7F, "R4");
    frame(9, 32'h1FF, "R5");
    frame(8, 32'h3C, "R8");        // accepted right after a reject
    frame(16, 32'hFFFF, "R5");
    frame(24, 32'h00C3C3, "R5");   // would wrap to eight without saturation

    begin : r6_stray
      int v0, e0;
      logic [7:0] prev;
      v0 = n_valid; e0 = n_error; prev = byte_out;
      ser_dat = 1'b1;
      stray_clocks(5);
      idle(6);
      chk(n_valid == v0 && n_error == e0, "R6", "pulses on stray clocks",
          n_valid - v0 + n_error - e0, 0);
      chk(byte_out == prev, "R6", "byte after stray clocks", byte_out, prev);
      frame(8, 32'h5A, "R6");
    end

    for (int k = 0; k < 40; k++) begin
      int n;
      logic [31:0] pat;
      n = ($urandom_range(0, 1) == 1) ? 8 : int'($urandom_range(0, 12));
      pat = $urandom();
      frame(n, pat, accepted(n) ? "R3" : (n < 8 ? "R4" : "R5"));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule